// File: doc/BRIEF.md
# Single-Precision Rounding Stage

This block sits behind an arithmetic datapath. It turns an unrounded intermediate value into a packed 32-bit IEEE single-precision word and three exception flags. The operand is a sign, a signed binary exponent and a 32-bit significand. The significand is read with two integer bits, so its value is `in_sig * 2^(in_exp - 30)`. A sticky bit stands for any nonzero bits below `in_sig`'s least significant bit. The upstream unit may therefore pass any operand that rounds like the exact result: all low-order detail can be compressed into the sticky bit. The significand may carry leading zeros of any count.

Rounding runs as a three-stage pipeline.
- The first stage normalizes the operand. When the operand lies below the smallest normal exponent, it shifts the significand right, pins the exponent there and folds the lost bits into the sticky bit.
- The second stage rounds the significand to 23 fraction bits under the selected mode.
- The third stage handles the two edge outcomes of that rounding: a carry to 2.0 and a result of zero. It also detects overflow and packs the word.

A valid bit travels alongside the data.

Top module: `fp_round_unit`

## Requirements
- R1: With `in_mode` = 2'b00 the result is the representable value nearest the operand. At an exact tie it is the neighbour whose fraction LSB is 0.
- R2: `in_mode` = 2'b01 truncates toward zero. 2'b10 rounds toward +infinity. 2'b11 rounds toward -infinity.
- R3: Operands with any number of leading zeros, or with a significand of 2.0 or more, are normalized before rounding, so the result does not depend on how the value is scaled between `in_sig` and `in_exp`.
- R4: `in_sticky` = 1 makes the operand strictly greater in magnitude than `in_sig` alone. It breaks ties and sets inexact.
- R5: When rounding carries the significand to 2.0, the exponent is incremented and the fraction field is 0.
- R6: A result below 2^-126 is packed with exponent field 0 and a fraction on the 2^-149 grid. A denormal that rounds up to 2^-126 is packed with exponent field 1.
- R7: A zero result from an operand of exactly zero has sign 1 only in mode 2'b11. A zero produced by rounding a nonzero operand keeps the operand's sign.
- R8: When the rounded exponent exceeds 127, overflow and inexact are both 1. The result is infinity (exponent field 255, fraction 0) in mode 2'b00 and in the directed mode that moves away from zero for that sign. In the other modes it is the largest finite value (exponent field 254, fraction all ones).
- R9: Inexact is 1 when the rounded value differs from the operand. Underflow is 1 when the operand is below 2^-126 before rounding and the result is inexact.
- R10: A result appears on the outputs exactly 3 clock cycles after its operand is accepted. It is marked by `out_valid`. Back-to-back operands give back-to-back results, and reset clears all pending valid bits.
- R11: The block never emits a NaN encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_mode | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| in_sign | input | 1 | Operand sign |
| in_exp | input | 10 | Signed two's-complement exponent |
| in_sig | input | 32 | Significand, value `in_sig * 2^(in_exp-30)` |
| in_sticky | input | 1 | OR of all bits below `in_sig` |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 32 | Packed sign, biased exponent, fraction |
| out_inexact | output | 1 | Rounded value differs from operand |
| out_overflow | output | 1 | Exponent above finite range |
| out_underflow | output | 1 | Tiny before rounding and inexact |

## Verification
The carry to 2.0 from significand rounding and the overflow decision can land in the same cycle. This happens when an all-ones significand at exponent 127 rounds up. The bench provokes it in nearest mode, where it must produce infinity with both overflow and inexact set. The same collision at the other end of the range is a largest denormal carrying into the smallest normal. There the exponent field must read 1 while underflow is still reported.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_TO_ZERO   = 2'b01,
    RM_UP        = 2'b10,
    RM_DOWN      = 2'b11
  } rmode_e;
endpackage

// File: rtl/fpr_prenorm.sv
// Stage 1: leading-one normalization, then right shift to the minimum exponent for tiny values.
module fpr_prenorm #(
  parameter int SIG_W  = 32,
  parameter int EXPI_W = 10,
  parameter int EW     = EXPI_W + 2,
  parameter int EMIN   = -126
) (
  input  logic [SIG_W-1:0]        in_sig,
  input  logic [EXPI_W-1:0]       in_exp,
  input  logic                    in_sticky,
  output logic [SIG_W-1:0]        n_sig,
  output logic signed [EW-1:0]    n_exp,
  output logic                    n_sticky,
  output logic                    n_tiny
);
  localparam int LZW = $clog2(SIG_W);
  localparam int SHW = LZW + 1;

  logic [LZW-1:0]           lead_pos;
  logic [LZW-1:0]           lsh;
  logic                     is_zero;
  logic [SIG_W-1:0]         norm;
  logic signed [EW-1:0]     exp_ext;
  logic signed [EW-1:0]     e_norm;
  logic signed [EW-1:0]     deficit;
  logic [SHW-1:0]           dshift;
  logic                     lost;

  always_comb begin
    lead_pos = '0;
    for (int i = 0; i < SIG_W; i++) begin
      if (in_sig[i]) lead_pos = LZW'(i);
    end
  end

  always_comb begin
    is_zero = (in_sig == '0);
    lsh     = LZW'(SIG_W - 1) - lead_pos;
    norm    = in_sig << lsh;
    exp_ext = {{(EW-EXPI_W){in_exp[EXPI_W-1]}}, in_exp};
    e_norm  = exp_ext + $signed({{(EW-LZW){1'b0}}, lead_pos}) - $signed(EW'(SIG_W - 2));
    deficit = $signed(EW'(EMIN)) - e_norm;
    if (deficit <= 0)                         dshift = '0;
    else if (deficit >= $signed(EW'(SIG_W)))  dshift = SHW'(SIG_W);
    else                                      dshift = deficit[SHW-1:0];
  end

  always_comb begin
    lost = 1'b0;
    for (int i = 0; i < SIG_W; i++) begin
      if (norm[i] && (SHW'(i) < dshift)) lost = 1'b1;
    end
  end

  always_comb begin
    n_sig    = norm >> dshift;
    n_sticky = in_sticky | lost;
    n_tiny   = is_zero | (deficit > 0);
    n_exp    = (is_zero || deficit > 0) ? $signed(EW'(EMIN)) : e_norm;
  end
endmodule

// File: rtl/fpr_siground.sv
// Stage 2: round the significand to FRAC_W fraction bits under the selected mode.
module fpr_siground #(
  parameter int SIG_W  = 32,
  parameter int FRAC_W = 23
) (
  input  logic                sign,
  input  logic [1:0]          mode,
  input  logic [SIG_W-1:0]    sig,
  input  logic                sticky,
  output logic [FRAC_W+1:0]   r_sig,
  output logic                r_inexact
);
  import fpr_pkg::*;

  localparam int KEEP_W = FRAC_W + 1;
  localparam int G_POS  = SIG_W - KEEP_W - 1;

  logic [KEEP_W-1:0] kept;
  logic              guard;
  logic              rest;
  logic              inc;

  always_comb begin
    kept      = sig[SIG_W-1 -: KEEP_W];
    guard     = sig[G_POS];
    rest      = (|sig[G_POS-1:0]) | sticky;
    r_inexact = guard | rest;
    unique case (rmode_e'(mode))
      RM_NEAR_EVEN: inc = guard & (rest | kept[0]);
      RM_TO_ZERO:   inc = 1'b0;
      RM_UP:        inc = ~sign & r_inexact;
      RM_DOWN:      inc = sign & r_inexact;
      default:      inc = 1'b0;
    endcase
    r_sig = {1'b0, kept} + {{KEEP_W{1'b0}}, inc};
  end
endmodule

// File: rtl/fpr_postnorm.sv
// Stage 3: fix the carry-to-2 and zero outcomes, detect overflow, pack the word.
module fpr_postnorm #(
  parameter int EW     = 12,
  parameter int FRAC_W = 23,
  parameter int EXPF_W = 8,
  parameter int BIAS   = 127
) (
  input  logic                 sign,
  input  logic [1:0]           mode,
  input  logic signed [EW-1:0] exp_i,
  input  logic [FRAC_W+1:0]    r_sig,
  input  logic                 inexact_i,
  input  logic                 tiny,
  output logic [EXPF_W+FRAC_W:0] result,
  output logic                 inexact_o,
  output logic                 overflow_o,
  output logic                 underflow_o
);
  import fpr_pkg::*;

  localparam int MAXB = (1 << EXPF_W) - 2;

  logic                  carry;
  logic                  is_norm;
  logic                  is_zero;
  logic signed [EW-1:0]  exp_adj;
  logic signed [EW-1:0]  biased_w;
  logic [FRAC_W-1:0]     frac;
  logic                  ovf;
  logic                  to_inf;
  logic                  zsign;

  always_comb begin
    carry    = r_sig[FRAC_W+1];
    is_norm  = carry | r_sig[FRAC_W];
    is_zero  = (r_sig == '0);
    exp_adj  = exp_i + $signed({{(EW-1){1'b0}}, carry});
    biased_w = exp_adj + $signed(EW'(BIAS));
    frac     = carry ? '0 : r_sig[FRAC_W-1:0];
    ovf      = is_norm && (biased_w > $signed(EW'(MAXB)));
    zsign    = inexact_i ? sign : (rmode_e'(mode) == RM_DOWN);
    unique case (rmode_e'(mode))
      RM_NEAR_EVEN: to_inf = 1'b1;
      RM_TO_ZERO:   to_inf = 1'b0;
      RM_UP:        to_inf = ~sign;
      RM_DOWN:      to_inf = sign;
      default:      to_inf = 1'b1;
    endcase
    if (is_zero)
      result = {zsign, {(EXPF_W+FRAC_W){1'b0}}};
    else if (ovf)
      result = to_inf ? {sign, {EXPF_W{1'b1}}, {FRAC_W{1'b0}}}
                      : {sign, EXPF_W'(MAXB), {FRAC_W{1'b1}}};
    else if (is_norm)
      result = {sign, biased_w[EXPF_W-1:0], frac};
    else
      result = {sign, {EXPF_W{1'b0}}, frac};
    inexact_o   = inexact_i | ovf;
    overflow_o  = ovf;
    underflow_o = tiny & inexact_i;
  end
endmodule

// File: rtl/fp_round_unit.sv
module fp_round_unit #(
  parameter int SIG_W  = 32,
  parameter int EXPI_W = 10,
  parameter int FRAC_W = 23,
  parameter int EXPF_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [1:0]               in_mode,
  input  logic                     in_sign,
  input  logic [EXPI_W-1:0]        in_exp,
  input  logic [SIG_W-1:0]         in_sig,
  input  logic                     in_sticky,
  output logic                     out_valid,
  output logic [EXPF_W+FRAC_W:0]   out_result,
  output logic                     out_inexact,
  output logic                     out_overflow,
  output logic                     out_underflow
);
  localparam int EW   = EXPI_W + 2;
  localparam int BIAS = (1 << (EXPF_W - 1)) - 1;
  localparam int EMIN = 1 - BIAS;
  localparam int RW   = EXPF_W + FRAC_W + 1;

  // stage 1 next / registered
  logic [SIG_W-1:0]      n1_sig;
  logic signed [EW-1:0]  n1_exp;
  logic                  n1_sticky, n1_tiny;
  logic                  s1_valid, s1_sign, s1_sticky, s1_tiny;
  logic [1:0]            s1_mode;
  logic [SIG_W-1:0]      s1_sig;
  logic signed [EW-1:0]  s1_exp;

  // stage 2
  logic [FRAC_W+1:0]     n2_rsig;
  logic                  n2_inexact;
  logic                  s2_valid, s2_sign, s2_inexact, s2_tiny;
  logic [1:0]            s2_mode;
  logic [FRAC_W+1:0]     s2_rsig;
  logic signed [EW-1:0]  s2_exp;

  // stage 3
  logic [RW-1:0]         n3_result;
  logic                  n3_inexact, n3_overflow, n3_underflow;

  fpr_prenorm #(.SIG_W(SIG_W), .EXPI_W(EXPI_W), .EW(EW), .EMIN(EMIN)) u_prenorm (
    .in_sig(in_sig), .in_exp(in_exp), .in_sticky(in_sticky),
    .n_sig(n1_sig), .n_exp(n1_exp), .n_sticky(n1_sticky), .n_tiny(n1_tiny)
  );

  fpr_siground #(.SIG_W(SIG_W), .FRAC_W(FRAC_W)) u_siground (
    .sign(s1_sign), .mode(s1_mode), .sig(s1_sig), .sticky(s1_sticky),
    .r_sig(n2_rsig), .r_inexact(n2_inexact)
  );

  fpr_postnorm #(.EW(EW), .FRAC_W(FRAC_W), .EXPF_W(EXPF_W), .BIAS(BIAS)) u_postnorm (
    .sign(s2_sign), .mode(s2_mode), .exp_i(s2_exp), .r_sig(s2_rsig),
    .inexact_i(s2_inexact), .tiny(s2_tiny),
    .result(n3_result), .inexact_o(n3_inexact),
    .overflow_o(n3_overflow), .underflow_o(n3_underflow)
  );

  // valid chain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s2_valid  <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      s1_valid  <= in_valid;
      s2_valid  <= s1_valid;
      out_valid <= s2_valid;
    end
  end

  // data registers, loaded only under their stage's valid
  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_sign   <= in_sign;
      s1_mode   <= in_mode;
      s1_sig    <= n1_sig;
      s1_exp    <= n1_exp;
      s1_sticky <= n1_sticky;
      s1_tiny   <= n1_tiny;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_valid) begin
      s2_sign    <= s1_sign;
      s2_mode    <= s1_mode;
      s2_exp     <= s1_exp;
      s2_rsig    <= n2_rsig;
      s2_inexact <= n2_inexact;
      s2_tiny    <= s1_tiny;
    end
  end

  always_ff @(posedge clk) begin
    if (s2_valid) begin
      out_result    <= n3_result;
      out_inexact   <= n3_inexact;
      out_overflow  <= n3_overflow;
      out_underflow <= n3_underflow;
    end
  end
endmodule

// File: rtl/fp_round_unit_chk.sv
module fp_round_unit_chk #(
  parameter int FRAC_W = 23,
  parameter int EXPF_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   out_valid,
  input logic [EXPF_W+FRAC_W:0] out_result,
  input logic                   out_inexact,
  input logic                   out_overflow,
  input logic                   out_underflow
);
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R10: fixed three-cycle latency of the valid bit
  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R8: overflow is always reported as inexact
  assert_ovf_inexact_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_overflow) |-> out_inexact);

  // R8: overflow result is infinity or the largest finite value
  assert_ovf_field_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_overflow) |->
      (out_result[FRAC_W +: EXPF_W] >= {{(EXPF_W-1){1'b1}}, 1'b0}));

  // R9: underflow only with inexact
  assert_unf_inexact_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_underflow) |-> out_inexact);

  // R11: all-ones exponent only as infinity from overflow
  assert_no_nan_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (&out_result[FRAC_W +: EXPF_W])) |->
      ((out_result[FRAC_W-1:0] == '0) && out_overflow));
endmodule

bind fp_round_unit fp_round_unit_chk #(.FRAC_W(FRAC_W), .EXPF_W(EXPF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_result(out_result), .out_inexact(out_inexact),
  .out_overflow(out_overflow), .out_underflow(out_underflow)
);

// File: tb/fp_round_unit_bench.sv
`timescale 1ns/1ps
module fp_round_unit_bench;
  localparam int NTBL  = 25;
  localparam int NRND  = 400;
  localparam int QSZ   = 512;
  localparam int WDOG  = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_mode;
  logic        in_sign;
  logic [9:0]  in_exp;
  logic [31:0] in_sig;
  logic        in_sticky;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_inexact, out_overflow, out_underflow;

  always #2 clk = ~clk;

  fp_round_unit u_fp_round_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_sign(in_sign), .in_exp(in_exp), .in_sig(in_sig), .in_sticky(in_sticky),
    .out_valid(out_valid), .out_result(out_result), .out_inexact(out_inexact),
    .out_overflow(out_overflow), .out_underflow(out_underflow)
  );

  // {req[3:0], sign, mode[1:0], exp[9:0], sig[31:0], sticky, result[31:0], flags{inexact,overflow,underflow}}
  localparam logic [84:0] TBL [NTBL] = '{
    {4'd1,  1'b0, 2'd0, 10'd0,   32'h4000_0000, 1'b0, 32'h3F80_0000, 3'b000}, // R1 exact 1.0
    {4'd1,  1'b0, 2'd0, 10'd0,   32'h4000_0040, 1'b0, 32'h3F80_0000, 3'b100}, // R1 tie to even, down
    {4'd1,  1'b0, 2'd0, 10'd0,   32'h4000_00C0, 1'b0, 32'h3F80_0002, 3'b100}, // R1 tie to even, up
    {4'd4,  1'b0, 2'd0, 10'd0,   32'h4000_0040, 1'b1, 32'h3F80_0001, 3'b100}, // R4 sticky breaks tie
    {4'd2,  1'b0, 2'd1, 10'd0,   32'h4000_0040, 1'b1, 32'h3F80_0000, 3'b100}, // R2 toward zero
    {4'd2,  1'b1, 2'd2, 10'd0,   32'h4000_0040, 1'b0, 32'hBF80_0000, 3'b100}, // R2 up, negative
    {4'd2,  1'b1, 2'd3, 10'd0,   32'h4000_0040, 1'b0, 32'hBF80_0001, 3'b100}, // R2 down, negative
    {4'd2,  1'b0, 2'd2, 10'd0,   32'h4000_0001, 1'b0, 32'h3F80_0001, 3'b100}, // R2 up, tiny excess
    {4'd5,  1'b0, 2'd0, 10'd0,   32'h7FFF_FFC0, 1'b0, 32'h4000_0000, 3'b100}, // R5 carry to 2.0
    {4'd3,  1'b0, 2'd0, 10'd30,  32'h0000_0001, 1'b0, 32'h3F80_0000, 3'b000}, // R3 leading zeros
    {4'd3,  1'b0, 2'd0, 10'd0,   32'hFFFF_FFFF, 1'b0, 32'h4080_0000, 3'b100}, // R3 value >= 2
    {4'd8,  1'b0, 2'd0, 10'd128, 32'h4000_0000, 1'b0, 32'h7F80_0000, 3'b110}, // R8 nearest -> inf
    {4'd8,  1'b0, 2'd1, 10'd128, 32'h4000_0000, 1'b0, 32'h7F7F_FFFF, 3'b110}, // R8 zero -> max
    {4'd8,  1'b1, 2'd2, 10'd128, 32'h4000_0000, 1'b0, 32'hFF7F_FFFF, 3'b110}, // R8 up neg -> -max
    {4'd8,  1'b1, 2'd3, 10'd128, 32'h4000_0000, 1'b0, 32'hFF80_0000, 3'b110}, // R8 down neg -> -inf
    {4'd8,  1'b0, 2'd0, 10'd127, 32'h7FFF_FFC0, 1'b0, 32'h7F80_0000, 3'b110}, // R8 R5 carry into overflow
    {4'd8,  1'b0, 2'd0, 10'd127, 32'h7FFF_FF80, 1'b0, 32'h7F7F_FFFF, 3'b000}, // R8 largest finite, exact
    {4'd6,  1'b0, 2'd0, 10'h36B, 32'h4000_0000, 1'b0, 32'h0000_0001, 3'b000}, // R6 2^-149 exact
    {4'd9,  1'b0, 2'd0, 10'h36A, 32'h4000_0000, 1'b0, 32'h0000_0000, 3'b101}, // R9 2^-150 tie to zero
    {4'd6,  1'b0, 2'd2, 10'h36A, 32'h4000_0000, 1'b0, 32'h0000_0001, 3'b101}, // R6 2^-150 up
    {4'd7,  1'b1, 2'd1, 10'h36A, 32'h4000_0000, 1'b0, 32'h8000_0000, 3'b101}, // R7 rounded zero keeps sign
    {4'd7,  1'b0, 2'd3, 10'd0,   32'h0000_0000, 1'b0, 32'h8000_0000, 3'b000}, // R7 exact zero, down
    {4'd7,  1'b1, 2'd0, 10'd0,   32'h0000_0000, 1'b0, 32'h0000_0000, 3'b000}, // R7 exact zero, nearest
    {4'd6,  1'b0, 2'd0, 10'h381, 32'h7FFF_FF80, 1'b0, 32'h0080_0000, 3'b101}, // R6 R9 denormal to min normal
    {4'd9,  1'b0, 2'd0, 10'h381, 32'h4000_0000, 1'b0, 32'h0040_0000, 3'b000}  // R9 exact tiny, no underflow
  };

  int checks = 0;
  int failures = 0;
  int wr = 0;
  int rd = 0;
  logic [34:0] exq [QSZ];
  int          rq  [QSZ];
  logic [31:0] rng = 32'h1234_5678;

  function automatic logic [31:0] xs32(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  // Independent rounding model: {result, inexact, overflow, underflow}
  function automatic logic [34:0] ref_model(input logic sgn, input logic [1:0] md,
                                            input int ein, input logic [31:0] sg, input logic stk);
    int k, e, q, sh;
    longint s, n;
    logic g, r, inex, inc, ovf, tiny, toinf;
    logic [31:0] res;
    s = longint'(sg);
    if (sg == 32'd0) begin
      q = -126; tiny = 1'b1; n = 0; g = 1'b0; r = stk;
    end else begin
      k = 0;
      for (int i = 0; i < 32; i++) if (sg[i]) k = i;
      e = ein + k - 30;
      tiny = (e < -126);
      q = tiny ? -126 : e;
      sh = q - 23 - (ein - 30);
      if (sh <= 0) begin
        n = s <<< (-sh); g = 1'b0; r = stk;
      end else begin
        n = (sh >= 40) ? 0 : (s >> sh);
        g = (sh - 1 < 32) ? sg[sh-1] : 1'b0;
        r = stk | ((sh - 1 >= 40) ? (s != 0) : ((s & ((longint'(1) << (sh - 1)) - 1)) != 0));
      end
    end
    inex = g | r;
    case (md)
      2'd0: inc = g & (r | n[0]);
      2'd1: inc = 1'b0;
      2'd2: inc = ~sgn & inex;
      default: inc = sgn & inex;
    endcase
    n = n + longint'(inc);
    if (n == (longint'(1) << 24)) begin n = longint'(1) << 23; q = q + 1; end
    ovf = 1'b0;
    if (n == 0) res = {(inex ? sgn : (md == 2'd3)), 31'd0};
    else if (q > 127) begin
      ovf = 1'b1; inex = 1'b1;
      toinf = (md == 2'd0) || (md == 2'd2 && !sgn) || (md == 2'd3 && sgn);
      res = toinf ? {sgn, 8'hFF, 23'd0} : {sgn, 8'hFE, 23'h7FFFFF};
    end else if (n >= (longint'(1) << 23)) res = {sgn, 8'(q + 127), n[22:0]};
    else res = {sgn, 8'd0, n[22:0]};
    return {res, inex, ovf, tiny & inex};
  endfunction

  task automatic push(input logic sgn, input logic [1:0] md, input logic [9:0] ex,
                      input logic [31:0] sg, input logic stk, input logic [34:0] expv, input int req);
    @(negedge clk);
    in_valid = 1'b1; in_sign = sgn; in_mode = md; in_exp = ex; in_sig = sg; in_sticky = stk;
    exq[wr] = expv; rq[wr] = req; wr++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // output checker, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (rd >= wr) begin
        failures++;
        $display("FAIL R10 unexpected result %h, expected none", out_result);
      end else begin
        if ({out_result, out_inexact, out_overflow, out_underflow} !== exq[rd]) begin
          failures++;
          $display("FAIL R%0d item %0d: got %h flags %b%b%b, expected %h flags %b",
                   rq[rd], rd, out_result, out_inexact, out_overflow, out_underflow,
                   exq[rd][34:3], exq[rd][2:0]);
        end
        rd++;
      end
    end
  end

  // watchdog
  initial begin
    repeat (WDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired: actual hang, expected completion");
    report();
  end

  initial begin
    logic [34:0] ev;
    int ein;
    rst_n = 1'b0; in_valid = 1'b0; in_mode = 2'd0; in_sign = 1'b0;
    in_exp = '0; in_sig = '0; in_sticky = 1'b0;
    repeat (3) @(negedge clk);
    checks++;  // R10 reset state
    if (out_valid !== 1'b0) begin
      failures++; $display("FAIL R10 reset: out_valid=%b expected 0", out_valid);
    end
    rst_n = 1'b1;
    idle(2);

    // R10 reset clears in-flight valid bits
    @(negedge clk);
    in_valid = 1'b1; in_sig = 32'h4000_0000; in_exp = '0;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
        failures++; $display("FAIL R10 flush: out_valid=%b expected 0", out_valid);
      end
    end
    rst_n = 1'b1;
    idle(2);

    // table walked back-to-back (R10 throughput)
    for (int i = 0; i < NTBL; i++)
      push(TBL[i][80], TBL[i][79:78], TBL[i][77:68], TBL[i][67:36], TBL[i][35],
           TBL[i][34:0], int'(TBL[i][84:81]));
    idle(6);
    checks++;
    if (rd != wr) begin
      failures++; $display("FAIL R10 table results: got %0d expected %0d", rd, wr);
    end

    // pseudo-random sweep against the model, with bubbles (R1 R2 R3 R4 R6 R9)
    for (int i = 0; i < NRND; i++) begin
      logic [31:0] a, b, c, sg;
      rng = xs32(rng); a = rng;
      rng = xs32(rng); b = rng;
      rng = xs32(rng); c = rng;
      sg  = (b[7:0] == 8'd0) ? 32'd0 : (a >> b[12:8]);
      ein = int'(c % 351) - 200;
      ev  = ref_model(b[16], b[18:17], ein, sg, b[19]);
      push(b[16], b[18:17], 10'(ein), sg, b[19], ev, 1);
      if (b[20]) idle(1);
    end
    idle(6);
    checks++;
    if (rd != wr) begin
      failures++; $display("FAIL R10 sweep results: got %0d expected %0d", rd, wr);
    end
    report();
  end
endmodule